// File: doc/BRIEF.md
# Exception Entry and Register Banking Controller

This block steers a 32-bit RISC core into its handlers. Each cycle it takes the event requests (reset, general exception, TLB-miss exception, trap, interrupt) together with the core's current program counter, general register 15 and delay-slot flag. When an event is accepted it loads the saved-PC, saved-status and saved-stack registers, writes the event code into the exception or interrupt event register, and sets the new program counter from the vector base plus an offset that depends on the kind of event.

The block also owns the status word, the FPU status word and the vector base. Software writes to these registers go through it. Whenever the status register's bank-select bit changes, for any reason, it pulses a bank-swap output so that the register file exchanges its eight low general registers with their shadow copies. A toggle of the FPU register-bank bit pulses a separate FP bank-swap output. The register file, instruction decode and interrupt priority selection are outside this block.

A general exception or trap raised while the vector base is still zero does not vector. The block halts and raises an error flag until a reset arrives.

Top module: `xent_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the outputs read: pc 0xA0000000, next pc 0xA0000002, status 0x700000F0, FPU status 0x00040001, vector base 0, exception event 0, halted 0, and every pulse output 0.
- R2: On an exception, trap or interrupt entry, saved status = the old status, saved stack = `cur_sp`, and the new status = the old status with bits 30 (privileged), 29 (bank select) and 28 (block) set. Outputs update one cycle after the request, with `entry_taken` high for that cycle.
- R3: The new pc is vector base + 0x100 for a general exception or trap, + 0x400 for a TLB-miss exception (`exc_tlb`=1), and + 0x600 for an interrupt. The next-pc output always equals pc + 2.
- R4: For an exception or trap with `in_slot`=1, saved pc = `cur_pc` − 2, and `slot_clr` pulses together with `entry_taken`. Otherwise saved pc = `cur_pc` and `slot_clr` stays 0.
- R5: A trap loads the trap-code output with its 8-bit immediate shifted left by 2, and loads the exception event with 0x160.
- R6: A general exception or trap with vector base 0 takes no entry and changes no pc, status or saved register. Instead `halted` is set. `halted` stays set, and exceptions, traps and interrupts are ignored, until `rst` or a reset request.
- R7: A reset request clears the vector base and `halted`, sets pc to 0xA0000000, writes `rst_code` into the exception event, sets the status to (old | bits 30,29,28,7:4) with bit 15 (FPU disable) cleared, and restores the FPU status to 0x00040001.
- R8: A status write stores `sr_wdata` AND 0x700083F3. `bank_swap` is high in the cycle the new status first appears if bit 29 changed, whether by a write, an entry or a reset request, and is low otherwise.
- R9: An FPU status write stores `fpsr_wdata` AND 0x003FFFFF. `fp_bank_swap` is high in the cycle the new value first appears if bit 21 toggled, and is low otherwise.
- R10: Priority when requests arrive in the same cycle: reset request, then exception, then trap, then interrupt. At most one entry happens per cycle. Register writes take effect only in cycles with no accepted or halting event.
- R11: An interrupt writes `irq_code` into the interrupt event, leaves the exception event unchanged, saves `cur_pc` without delay-slot adjustment, and never halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset event request |
| rst_code | input | 12 | Event code recorded by a reset request |
| req_exc | input | 1 | General or TLB-miss exception request |
| exc_code | input | 12 | Exception event code |
| exc_tlb | input | 1 | Exception is a TLB miss |
| req_trap | input | 1 | Trap request |
| trap_imm | input | 8 | Trap immediate |
| req_irq | input | 1 | Interrupt request (already arbitrated) |
| irq_code | input | 12 | Interrupt event code |
| cur_pc | input | 32 | PC of the current instruction |
| cur_sp | input | 32 | Current general register 15 |
| in_slot | input | 1 | Current instruction is in a delay slot |
| sr_we | input | 1 | Status write enable |
| sr_wdata | input | 32 | Status write data |
| fpsr_we | input | 1 | FPU status write enable |
| fpsr_wdata | input | 32 | FPU status write data |
| vbr_we | input | 1 | Vector base write enable |
| vbr_wdata | input | 32 | Vector base write data |
| entry_taken | output | 1 | Entry (including reset) took place |
| pc_out | output | 32 | Current PC |
| next_pc | output | 32 | Following PC |
| sr_out | output | 32 | Status register |
| fpsr_out | output | 32 | FPU status register |
| vbr_out | output | 32 | Vector base |
| saved_pc | output | 32 | Saved PC |
| saved_sr | output | 32 | Saved status |
| saved_sp | output | 32 | Saved stack pointer |
| expevt_out | output | 12 | Exception event register |
| intevt_out | output | 12 | Interrupt event register |
| tra_out | output | 32 | Trap-code register |
| slot_clr | output | 1 | Pulse: clear the delay-slot flag |
| halted | output | 1 | Halted on an uninitialised vector base |
| bank_swap | output | 1 | Pulse: swap general register bank |
| fp_bank_swap | output | 1 | Pulse: swap FP register bank |

## Verification
A wrong event kind or a wrong priority decision shows up one cycle after the request. The pc lands on the wrong vector offset, or the exception and interrupt event registers change when they should hold. A stale copy of the bank bit shows up as a missing or extra `bank_swap` pulse in that same cycle. The register file would then run on the wrong bank from then on, so every pulse is checked against the bit 29 transition it accompanies. A halt flag that fails to stay set becomes visible at the first exception or interrupt presented while halted, when the pc moves.

// File: rtl/xent_pkg.sv
package xent_pkg;
    parameter int XLEN   = 32;
    parameter int CODE_W = 12;
    parameter int IMM_W  = 8;

    localparam logic [XLEN-1:0] ST_PRIV   = XLEN'(1) << 30;
    localparam logic [XLEN-1:0] ST_BANK   = XLEN'(1) << 29;
    localparam logic [XLEN-1:0] ST_BLOCK  = XLEN'(1) << 28;
    localparam logic [XLEN-1:0] ST_FPOFF  = XLEN'(1) << 15;
    localparam logic [XLEN-1:0] ST_IMASK  = XLEN'(32'h0000_00F0);
    localparam logic [XLEN-1:0] ST_WMASK  = XLEN'(32'h7000_83F3);
    localparam logic [XLEN-1:0] ST_INIT   = XLEN'(32'h7000_00F0);
    localparam logic [XLEN-1:0] FP_FRBIT  = XLEN'(1) << 21;
    localparam logic [XLEN-1:0] FP_WMASK  = XLEN'(32'h003F_FFFF);
    localparam logic [XLEN-1:0] FP_INIT   = XLEN'(32'h0004_0001);
    localparam logic [XLEN-1:0] BOOT_PC   = XLEN'(32'hA000_0000);
    localparam logic [XLEN-1:0] OFS_GEN   = XLEN'(32'h100);
    localparam logic [XLEN-1:0] OFS_TLB   = XLEN'(32'h400);
    localparam logic [XLEN-1:0] OFS_IRQ   = XLEN'(32'h600);
    localparam logic [CODE_W-1:0] TRAP_EVT = CODE_W'(12'h160);

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_RESET = 3'd1,
        EV_EXC   = 3'd2,
        EV_TRAP  = 3'd3,
        EV_IRQ   = 3'd4,
        EV_HALT  = 3'd5
    } ev_kind_e;

    typedef struct packed {
        logic              take;
        logic              save;
        logic              halt_set;
        logic              slot_clr;
        logic              vbr_clr;
        logic              fp_init;
        logic              wr_exp;
        logic              wr_int;
        logic              wr_tra;
        logic [XLEN-1:0]   new_pc;
        logic [XLEN-1:0]   saved_pc;
        logic [XLEN-1:0]   new_sr;
        logic [CODE_W-1:0] exp_code;
        logic [CODE_W-1:0] int_code;
        logic [XLEN-1:0]   tra_val;
    } entry_t;

    function automatic logic [XLEN-1:0] sr_on_entry(input logic [XLEN-1:0] sr);
        return sr | ST_PRIV | ST_BANK | ST_BLOCK;
    endfunction

    function automatic logic [XLEN-1:0] sr_on_reset(input logic [XLEN-1:0] sr);
        return (sr | ST_PRIV | ST_BANK | ST_BLOCK | ST_IMASK) & ~ST_FPOFF;
    endfunction
endpackage

// File: rtl/xent_arb.sv
module xent_arb
    import xent_pkg::*;
(
    input  logic     req_reset,
    input  logic     req_exc,
    input  logic     req_trap,
    input  logic     req_irq,
    input  logic     halted,
    input  logic     vbr_zero,
    output ev_kind_e kind
);
    always_comb begin
        if (req_reset)
            kind = EV_RESET;
        else if (halted)
            kind = EV_NONE;
        else if (req_exc || req_trap) begin
            if (vbr_zero)
                kind = EV_HALT;
            else
                kind = req_exc ? EV_EXC : EV_TRAP;
        end else if (req_irq)
            kind = EV_IRQ;
        else
            kind = EV_NONE;
    end
endmodule

// File: rtl/xent_target.sv
module xent_target
    import xent_pkg::*;
(
    input  ev_kind_e          kind,
    input  logic              exc_tlb,
    input  logic [XLEN-1:0]   vbr,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              in_slot,
    input  logic [XLEN-1:0]   sr,
    input  logic [CODE_W-1:0] rst_code,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [IMM_W-1:0]  trap_imm,
    output entry_t            ent
);
    logic [XLEN-1:0] slot_pc;
    logic [XLEN-1:0] gen_ofs;

    always_comb begin
        slot_pc = in_slot ? (cur_pc - XLEN'(2)) : cur_pc;
        gen_ofs = (kind == EV_EXC && exc_tlb) ? OFS_TLB : OFS_GEN;
    end

    always_comb begin
        ent          = '0;
        ent.new_sr   = sr;
        ent.new_pc   = cur_pc;
        ent.saved_pc = cur_pc;
        ent.tra_val  = XLEN'(trap_imm) << 2;
        unique case (kind)
            EV_RESET: begin
                ent.take     = 1'b1;
                ent.vbr_clr  = 1'b1;
                ent.fp_init  = 1'b1;
                ent.new_pc   = BOOT_PC;
                ent.new_sr   = sr_on_reset(sr);
                ent.wr_exp   = 1'b1;
                ent.exp_code = rst_code;
            end
            EV_EXC, EV_TRAP: begin
                ent.take     = 1'b1;
                ent.save     = 1'b1;
                ent.saved_pc = slot_pc;
                ent.slot_clr = in_slot;
                ent.new_pc   = vbr + gen_ofs;
                ent.new_sr   = sr_on_entry(sr);
                ent.wr_exp   = 1'b1;
                ent.exp_code = (kind == EV_TRAP) ? TRAP_EVT : exc_code;
                ent.wr_tra   = (kind == EV_TRAP);
            end
            EV_IRQ: begin
                ent.take     = 1'b1;
                ent.save     = 1'b1;
                ent.new_pc   = vbr + OFS_IRQ;
                ent.new_sr   = sr_on_entry(sr);
                ent.wr_int   = 1'b1;
                ent.int_code = irq_code;
            end
            EV_HALT: ent.halt_set = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/xent_toggle.sv
module xent_toggle #(
    parameter int          W   = 32,
    parameter logic [W-1:0] SEL = '0
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    output logic         flip
);
    always_comb flip = |((old_val ^ new_val) & SEL);
endmodule

// File: rtl/xent_ctrl.sv
module xent_ctrl
    import xent_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_reset,
    input  logic [CODE_W-1:0] rst_code,
    input  logic              req_exc,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_tlb,
    input  logic              req_trap,
    input  logic [IMM_W-1:0]  trap_imm,
    input  logic              req_irq,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_sp,
    input  logic              in_slot,
    input  logic              sr_we,
    input  logic [XLEN-1:0]   sr_wdata,
    input  logic              fpsr_we,
    input  logic [XLEN-1:0]   fpsr_wdata,
    input  logic              vbr_we,
    input  logic [XLEN-1:0]   vbr_wdata,
    output logic              entry_taken,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   next_pc,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   fpsr_out,
    output logic [XLEN-1:0]   vbr_out,
    output logic [XLEN-1:0]   saved_pc,
    output logic [XLEN-1:0]   saved_sr,
    output logic [XLEN-1:0]   saved_sp,
    output logic [CODE_W-1:0] expevt_out,
    output logic [CODE_W-1:0] intevt_out,
    output logic [XLEN-1:0]   tra_out,
    output logic              slot_clr,
    output logic              halted,
    output logic              bank_swap,
    output logic              fp_bank_swap
);
    ev_kind_e        kind;
    entry_t          ent;
    logic            quiet;
    logic [XLEN-1:0] pc_q, npc_q, sr_q, fp_q, vbr_q;
    logic [XLEN-1:0] sr_nxt, fp_nxt, vbr_nxt, pc_nxt;
    logic            sr_flip, fp_flip;

    xent_arb u_arb (
        .req_reset (req_reset),
        .req_exc   (req_exc),
        .req_trap  (req_trap),
        .req_irq   (req_irq),
        .halted    (halted),
        .vbr_zero  (vbr_q == '0),
        .kind      (kind)
    );

    xent_target u_tgt (
        .kind     (kind),
        .exc_tlb  (exc_tlb),
        .vbr      (vbr_q),
        .cur_pc   (cur_pc),
        .in_slot  (in_slot),
        .sr       (sr_q),
        .rst_code (rst_code),
        .exc_code (exc_code),
        .irq_code (irq_code),
        .trap_imm (trap_imm),
        .ent      (ent)
    );

    // Register writes only in cycles with no event of any kind.
    always_comb begin
        quiet = (kind == EV_NONE);
        pc_nxt = ent.take ? ent.new_pc : pc_q;
        if (ent.take)
            sr_nxt = ent.new_sr;
        else if (quiet && sr_we)
            sr_nxt = sr_wdata & ST_WMASK;
        else
            sr_nxt = sr_q;
        if (ent.fp_init)
            fp_nxt = FP_INIT;
        else if (quiet && fpsr_we)
            fp_nxt = fpsr_wdata & FP_WMASK;
        else
            fp_nxt = fp_q;
        if (ent.vbr_clr)
            vbr_nxt = '0;
        else if (quiet && vbr_we)
            vbr_nxt = vbr_wdata;
        else
            vbr_nxt = vbr_q;
    end

    xent_toggle #(.W(XLEN), .SEL(ST_BANK)) u_gr_flip (
        .old_val (sr_q),
        .new_val (sr_nxt),
        .flip    (sr_flip)
    );

    xent_toggle #(.W(XLEN), .SEL(FP_FRBIT)) u_fp_flip (
        .old_val (fp_q),
        .new_val (fp_nxt),
        .flip    (fp_flip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q         <= BOOT_PC;
            npc_q        <= BOOT_PC + XLEN'(2);
            sr_q         <= ST_INIT;
            fp_q         <= FP_INIT;
            vbr_q        <= '0;
            saved_pc     <= '0;
            saved_sr     <= '0;
            saved_sp     <= '0;
            expevt_out   <= '0;
            intevt_out   <= '0;
            tra_out      <= '0;
            halted       <= 1'b0;
            entry_taken  <= 1'b0;
            slot_clr     <= 1'b0;
            bank_swap    <= 1'b0;
            fp_bank_swap <= 1'b0;
        end else begin
            pc_q         <= pc_nxt;
            npc_q        <= pc_nxt + XLEN'(2);
            sr_q         <= sr_nxt;
            fp_q         <= fp_nxt;
            vbr_q        <= vbr_nxt;
            entry_taken  <= ent.take;
            slot_clr     <= ent.slot_clr;
            bank_swap    <= sr_flip;
            fp_bank_swap <= fp_flip;
            if (ent.save) begin
                saved_pc <= ent.saved_pc;
                saved_sr <= sr_q;
                saved_sp <= cur_sp;
            end
            if (ent.wr_exp) expevt_out <= ent.exp_code;
            if (ent.wr_int) intevt_out <= ent.int_code;
            if (ent.wr_tra) tra_out    <= ent.tra_val;
            if (kind == EV_RESET)
                halted <= 1'b0;
            else if (ent.halt_set)
                halted <= 1'b1;
        end
    end

    always_comb begin
        pc_out   = pc_q;
        next_pc  = npc_q;
        sr_out   = sr_q;
        fpsr_out = fp_q;
        vbr_out  = vbr_q;
    end
endmodule

// File: rtl/xent_chk.sv
module xent_chk
    import xent_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_reset,
    input logic            entry_taken,
    input logic            halted,
    input logic            slot_clr,
    input logic            bank_swap,
    input logic            fp_bank_swap,
    input logic [XLEN-1:0] pc_out,
    input logic [XLEN-1:0] sr_out,
    input logic [XLEN-1:0] fpsr_out,
    input logic [XLEN-1:0] vbr_out
);
    logic [XLEN-1:0] ofs;
    always_comb ofs = pc_out - vbr_out;

    AST_ENTRY_PRIV: assert property (@(posedge clk) disable iff (rst)
        entry_taken |-> ((sr_out & (ST_PRIV | ST_BANK | ST_BLOCK)) == (ST_PRIV | ST_BANK | ST_BLOCK))); // R2
    AST_VECTOR_OFS: assert property (@(posedge clk) disable iff (rst)
        entry_taken |-> (pc_out == BOOT_PC || ofs == OFS_GEN || ofs == OFS_TLB || ofs == OFS_IRQ)); // R3
    AST_SLOT_WITH_ENTRY: assert property (@(posedge clk) disable iff (rst)
        slot_clr |-> entry_taken); // R4
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halted && !req_reset) |=> halted); // R6
    AST_HALT_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (halted && !req_reset) |=> !entry_taken); // R6
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
        req_reset |=> (pc_out == BOOT_PC && vbr_out == '0 && !halted)); // R7
    AST_BANK_PULSE: assert property (@(posedge clk) disable iff (rst)
        bank_swap |-> (sr_out[29] != $past(sr_out[29]))); // R8
    AST_FP_BANK_PULSE: assert property (@(posedge clk) disable iff (rst)
        fp_bank_swap |-> (fpsr_out[21] != $past(fpsr_out[21]))); // R9
endmodule

bind xent_ctrl xent_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_reset    (req_reset),
    .entry_taken  (entry_taken),
    .halted       (halted),
    .slot_clr     (slot_clr),
    .bank_swap    (bank_swap),
    .fp_bank_swap (fp_bank_swap),
    .pc_out       (pc_out),
    .sr_out       (sr_out),
    .fpsr_out     (fpsr_out),
    .vbr_out      (vbr_out)
);

// File: tb/sim_xent_ctrl.sv
module sim_xent_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_reset = 0, req_exc = 0, exc_tlb = 0, req_trap = 0, req_irq = 0;
    logic [11:0] rst_code = 0, exc_code = 0, irq_code = 0;
    logic [7:0]  trap_imm = 0;
    logic [31:0] cur_pc = 0, cur_sp = 0;
    logic        in_slot = 0;
    logic        sr_we = 0, fpsr_we = 0, vbr_we = 0;
    logic [31:0] sr_wdata = 0, fpsr_wdata = 0, vbr_wdata = 0;
    logic        entry_taken, slot_clr, halted, bank_swap, fp_bank_swap;
    logic [31:0] pc_out, next_pc, sr_out, fpsr_out, vbr_out, saved_pc, saved_sr, saved_sp, tra_out;
    logic [11:0] expevt_out, intevt_out;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xent_ctrl u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        req_reset = 0; req_exc = 0; exc_tlb = 0; req_trap = 0; req_irq = 0;
        in_slot = 0; sr_we = 0; fpsr_we = 0; vbr_we = 0;
    endtask

    // Inputs are set at a falling edge; result sampled at the next falling edge.
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 pc", pc_out, 32'hA000_0000);
        chk("R1 npc", next_pc, 32'hA000_0002);
        chk("R1 sr", sr_out, 32'h7000_00F0);
        chk("R1 fpsr", fpsr_out, 32'h0004_0001);
        chk("R1 vbr", vbr_out, 0);
        chk("R1 expevt", {20'd0, expevt_out}, 0);
        chk("R1 pulses", {27'd0, halted, entry_taken, slot_clr, bank_swap, fp_bank_swap}, 0);
    endtask

    task automatic t_halt_on_zero_base();
        req_exc = 1; exc_code = 12'h0E0; cur_pc = 32'h0C00_0010; cyc();
        chk("R6 halted", {31'd0, halted}, 1);
        chk("R6 no entry", {31'd0, entry_taken}, 0);
        chk("R6 pc held", pc_out, 32'hA000_0000);
        clear_in();
        req_irq = 1; irq_code = 12'h200; cyc();
        chk("R6 irq ignored pc", pc_out, 32'hA000_0000);
        chk("R6 irq ignored intevt", {20'd0, intevt_out}, 0);
        clear_in();
        req_reset = 1; rst_code = 12'h020; cyc();
        chk("R7 halt cleared", {31'd0, halted}, 0);
        chk("R7 expevt", {20'd0, expevt_out}, 32'h020);
        clear_in();
    endtask

    task automatic t_status_writes();
        vbr_we = 1; vbr_wdata = 32'h8C00_0000; cyc(); clear_in();
        chk("R10 vbr write", vbr_out, 32'h8C00_0000);
        sr_we = 1; sr_wdata = 32'h0000_00F3; cyc(); clear_in();
        chk("R8 sr", sr_out, 32'h0000_00F3);
        chk("R8 swap on clear", {31'd0, bank_swap}, 1);
        sr_we = 1; sr_wdata = 32'hFFFF_FFFF; cyc();
        chk("R8 masked", sr_out, 32'h7000_83F3);
        chk("R8 swap on set", {31'd0, bank_swap}, 1);
        cyc(); clear_in();
        chk("R8 no swap same", {31'd0, bank_swap}, 0);
        sr_we = 1; sr_wdata = 32'h0000_00F0; cyc(); clear_in();
    endtask

    task automatic t_exceptions();
        req_exc = 1; exc_code = 12'h0E0; cur_pc = 32'h0C00_1000; cur_sp = 32'h0000_1234; cyc(); clear_in();
        chk("R2 taken", {31'd0, entry_taken}, 1);
        chk("R2 saved pc", saved_pc, 32'h0C00_1000);
        chk("R2 saved sr", saved_sr, 32'h0000_00F0);
        chk("R2 saved sp", saved_sp, 32'h0000_1234);
        chk("R2 new sr", sr_out, 32'h7000_00F0);
        chk("R8 swap on entry", {31'd0, bank_swap}, 1);
        chk("R3 gen vector", pc_out, 32'h8C00_0100);
        chk("R3 npc", next_pc, 32'h8C00_0102);
        chk("R2 expevt", {20'd0, expevt_out}, 32'h0E0);
        req_exc = 1; exc_tlb = 1; exc_code = 12'h040; cur_pc = 32'h0C00_2002; in_slot = 1; cyc(); clear_in();
        chk("R3 tlb vector", pc_out, 32'h8C00_0400);
        chk("R4 slot saved pc", saved_pc, 32'h0C00_2000);
        chk("R4 slot_clr", {31'd0, slot_clr}, 1);
        chk("R8 no swap bank already set", {31'd0, bank_swap}, 0);
        req_trap = 1; trap_imm = 8'h2A; cur_pc = 32'h0C00_3000; cyc(); clear_in();
        chk("R5 tra", tra_out, 32'h0000_00A8);
        chk("R5 expevt", {20'd0, expevt_out}, 32'h160);
        chk("R3 trap vector", pc_out, 32'h8C00_0100);
        chk("R4 no slot_clr", {31'd0, slot_clr}, 0);
        req_irq = 1; irq_code = 12'h320; cur_pc = 32'h0C00_4002; in_slot = 1; cyc(); clear_in();
        chk("R11 irq vector", pc_out, 32'h8C00_0600);
        chk("R11 intevt", {20'd0, intevt_out}, 32'h320);
        chk("R11 expevt kept", {20'd0, expevt_out}, 32'h160);
        chk("R11 saved pc unadjusted", saved_pc, 32'h0C00_4002);
        chk("R11 no slot_clr", {31'd0, slot_clr}, 0);
    endtask

    task automatic t_priority();
        req_exc = 1; exc_code = 12'h1A0; req_irq = 1; irq_code = 12'h3C0;
        sr_we = 1; sr_wdata = 32'h0; cur_pc = 32'h0C00_5000; cyc(); clear_in();
        chk("R10 exc over irq pc", pc_out, 32'h8C00_0100);
        chk("R10 intevt untouched", {20'd0, intevt_out}, 32'h320);
        chk("R10 write dropped", sr_out, 32'h7000_00F0);
        req_trap = 1; trap_imm = 8'h01; req_irq = 1; cyc(); clear_in();
        chk("R10 trap over irq", tra_out, 32'h0000_0004);
        chk("R10 trap pc", pc_out, 32'h8C00_0100);
        req_reset = 1; rst_code = 12'h000; req_exc = 1; cyc(); clear_in();
        chk("R10 reset wins pc", pc_out, 32'hA000_0000);
        chk("R10 reset wins expevt", {20'd0, expevt_out}, 0);
    endtask

    task automatic t_fpu();
        fpsr_we = 1; fpsr_wdata = 32'h0024_0001; cyc(); clear_in();
        chk("R9 fpsr", fpsr_out, 32'h0024_0001);
        chk("R9 fp swap", {31'd0, fp_bank_swap}, 1);
        fpsr_we = 1; fpsr_wdata = 32'hFFFF_FFFF; cyc(); clear_in();
        chk("R9 fpsr masked", fpsr_out, 32'h003F_FFFF);
        chk("R9 no fp swap", {31'd0, fp_bank_swap}, 0);
    endtask

    task automatic t_reset_request();
        vbr_we = 1; vbr_wdata = 32'h8C00_0000; cyc(); clear_in();
        sr_we = 1; sr_wdata = 32'h0000_8000; cyc(); clear_in();
        req_reset = 1; rst_code = 12'h0A5; cyc(); clear_in();
        chk("R7 sr", sr_out, 32'h7000_00F0);
        chk("R7 vbr", vbr_out, 0);
        chk("R7 pc", pc_out, 32'hA000_0000);
        chk("R7 fpsr", fpsr_out, 32'h0004_0001);
        chk("R9 fp swap by reset", {31'd0, fp_bank_swap}, 1);
        chk("R8 swap by reset", {31'd0, bank_swap}, 1);
        chk("R7 code", {20'd0, expevt_out}, 32'h0A5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_state();
        t_halt_on_zero_base();
        t_status_writes();
        t_exceptions();
        t_priority();
        t_fpu();
        t_reset_request();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule